// File: doc/BRIEF.md
# Serial Port Register Block

This block is the software-visible shell of a serial port. Sitting between a 32-bit register bus and a frame engine (the shifter, baud timing and pin logic live elsewhere), it holds the configuration words the engine needs. It turns write-one command bits into receiver and transmitter enable state. It buffers up to two outgoing and two incoming words, and it folds buffer and completion conditions into an interrupt flag register that drives a receive and a transmit interrupt line.

Software writes words to the transmit data address. They leave for the engine through a valid/take handshake, but only while the transmitter is enabled. Words the engine receives arrive on a one-cycle strobe, together with parity and framing error bits. They queue until software reads the extended receive data address. That read returns the word and its error bits, and removes the word from the queue.

Top module: `serctl_regs`

## Requirements
- R1: After reset the transmitter and receiver are disabled and both buffers are empty. Status reads 0x60 (bit 5 transmit complete, bit 6 buffer room), the flag register reads 0x2, both interrupt lines are low, tx_valid is low and control reads 0.
- R2: Configuration storage has fixed writable bits and the rest read 0. Control (0x00) keeps bit 0 (synchronous mode, also on cfg_sync) and bit 12 (buffer-level select). Route (0x54) keeps bits 0, 1 and 10:8. Frame (0x04) and clock divider (0x14) keep all 32 bits.
- R3: A write to the command address (0x0C) acts as pulses. Bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. A disable bit wins over an enable bit in the same write. Status bit 1 shows transmitter enable.
- R4: A write to transmit data (0x34) stores bits DW-1:0 in a two-entry buffer, and a write while the buffer is full is dropped. While the transmitter is enabled, the words are offered on tx_word/tx_valid in write order, and each leaves when tx_take is high at a clock edge.
- R5: While the transmitter is disabled, no word is offered and the buffered words are kept. They are sent once it is enabled again.
- R6: The buffer-level condition appears in status bit 6 and flag bit 1. With control bit 12 clear it is high while at least one slot is free; with bit 12 set it is high only when the buffer is empty. Flag set and clear writes do not affect it.
- R7: Status bit 5 is high while the transmit buffer is empty and tx_idle is high. Flag bit 0 is set when that condition rises, and stays set until cleared.
- R8: Writing 1s to flag set (0x44) sets sticky flag bits 0 and 4, and writing 1s to flag clear (0x48) clears them. The flag register (0x40) holds transmit complete in bit 0, buffer level in bit 1, receive data valid in bit 2 and receive overflow in bit 4.
- R9: While the receiver is enabled, a strobe stores rx_word with its error bits in a two-entry buffer. Status bit 7 and flag bit 2 show the buffer is not empty. A read of 0x18 returns the oldest word in bits DW-1:0, parity error in bit 14 and framing error in bit 15, and removes it; the read returns 0 when the buffer is empty.
- R10: A strobe while both receive slots are full drops the word and sets flag bit 4.
- R11: While the receiver is disabled, strobes are ignored.
- R12: Interrupt enable (0x4C) keeps bits 0, 1, 2 and 4. irq_tx is the registered OR of the enabled flag bits 0 and 1, and irq_rx is the registered OR of the enabled flag bits 2 and 4.
- R13: Read data appears on bus_rdata after the clock edge that samples bus_rd. The command, set and clear addresses and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_word | output | DW | Word offered to the engine |
| tx_valid | output | 1 | A word is offered |
| tx_take | input | 1 | Engine takes the offered word |
| tx_idle | input | 1 | Engine shifter is empty |
| rx_word | input | DW | Received word |
| rx_perr | input | 1 | Parity error of rx_word |
| rx_ferr | input | 1 | Framing error of rx_word |
| rx_strobe | input | 1 | rx_word is valid this cycle |
| cfg_sync | output | 1 | Synchronous mode select |
| cfg_frame | output | 32 | Frame format word |
| cfg_clkdiv | output | 32 | Clock divider word |
| cfg_route | output | 32 | Pin route word |
| rx_active | output | 1 | Receiver enabled |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
A wrong buffer count or pointer shows within a few cycles. It appears as a missing, repeated or reordered word on the transmit handshake, or as the wrong word from a receive read. The level bits in status also go wrong for the same buffer state. A sticky flag that is set or cleared wrongly shows on the next flag read, and on the matching interrupt line one cycle after its enable changes. Enable state that has drifted shows at once as words sent or stored while the port should be stopped, or held while it should run.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam logic [7:0] ADR_CTRL   = 8'h00;
  localparam logic [7:0] ADR_FRAME  = 8'h04;
  localparam logic [7:0] ADR_CMD    = 8'h0C;
  localparam logic [7:0] ADR_STATUS = 8'h10;
  localparam logic [7:0] ADR_CLKDIV = 8'h14;
  localparam logic [7:0] ADR_RXDATA = 8'h18;
  localparam logic [7:0] ADR_TXDATA = 8'h34;
  localparam logic [7:0] ADR_FLAGS  = 8'h40;
  localparam logic [7:0] ADR_FSET   = 8'h44;
  localparam logic [7:0] ADR_FCLR   = 8'h48;
  localparam logic [7:0] ADR_IEN    = 8'h4C;
  localparam logic [7:0] ADR_ROUTE  = 8'h54;

  localparam int NFLAG = 5;
  localparam int FL_TXDONE = 0;
  localparam int FL_TXROOM = 1;
  localparam int FL_RXAVL  = 2;
  localparam int FL_RXOVF  = 4;

  localparam int CT_SYNC  = 0;
  localparam int CT_LEVEL = 12;

  localparam int CM_RXON  = 0;
  localparam int CM_RXOFF = 1;
  localparam int CM_TXON  = 2;
  localparam int CM_TXOFF = 3;

  localparam int ST_TXON   = 1;
  localparam int ST_TXDONE = 5;
  localparam int ST_TXROOM = 6;
  localparam int ST_RXAVL  = 7;

  localparam int RD_PERR = 14;
  localparam int RD_FERR = 15;

  localparam logic [31:0] ROUTE_MASK = 32'h0000_0703;
endpackage

// File: rtl/serctl_fifo.sv
module serctl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         full_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= nxt(wp);
      if (pop_i)  rp <= nxt(rp);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign data_o  = mem[rp];
  assign count_o = cnt;
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o || pop_i); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o); // R9
endmodule

// File: rtl/serctl_irq.sv
module serctl_irq #(
  parameter int            NF     = 5,
  parameter logic [NF-1:0] STICKY = 5'b10001,
  parameter logic [NF-1:0] LIVE   = 5'b00110,
  parameter logic [NF-1:0] TXGRP  = 5'b00011,
  parameter logic [NF-1:0] RXGRP  = 5'b10100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] hw_set_i,
  input  logic [NF-1:0] live_i,
  input  logic          ien_we_i,
  input  logic [NF-1:0] ien_d_i,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] ien_o,
  output logic          irq_tx_o,
  output logic          irq_rx_o
);
  localparam logic [NF-1:0] IMPL = STICKY | LIVE;

  logic [NF-1:0] ien;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    if (STICKY[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= (q & ~clr_i[i]) | hw_set_i[i] | set_i[i];
      end
      assign flags_o[i] = q;
      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q && !clr_i[i]) |=> q); // R7
    end else if (LIVE[i]) begin : g_live
      assign flags_o[i] = live_i[i];
    end else begin : g_none
      assign flags_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien      <= '0;
      irq_tx_o <= 1'b0;
      irq_rx_o <= 1'b0;
    end else begin
      if (ien_we_i) ien <= ien_d_i & IMPL;
      irq_tx_o <= |(flags_o & ien & TXGRP);
      irq_rx_o <= |(flags_o & ien & RXGRP);
    end
  end

  assign ien_o = ien;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> (!irq_tx_o && !irq_rx_o)); // R12
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs #(
  parameter int DW    = 9,
  parameter int DEPTH = 2,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [DW-1:0] tx_word,
  output logic          tx_valid,
  input  logic          tx_take,
  input  logic          tx_idle,
  input  logic [DW-1:0] rx_word,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_strobe,
  output logic          cfg_sync,
  output logic [31:0]   cfg_frame,
  output logic [31:0]   cfg_clkdiv,
  output logic [31:0]   cfg_route,
  output logic          rx_active,
  output logic          irq_rx,
  output logic          irq_tx
);
  import serctl_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = DW + 2;

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] r);
    return a == AW'(r);
  endfunction

  logic wr_ctrl, wr_frame, wr_cmd, wr_clkdiv, wr_tx, wr_fset, wr_fclr, wr_ien, wr_route;
  logic rd_rx;

  assign wr_ctrl   = bus_wr && hit(bus_addr, ADR_CTRL);
  assign wr_frame  = bus_wr && hit(bus_addr, ADR_FRAME);
  assign wr_cmd    = bus_wr && hit(bus_addr, ADR_CMD);
  assign wr_clkdiv = bus_wr && hit(bus_addr, ADR_CLKDIV);
  assign wr_tx     = bus_wr && hit(bus_addr, ADR_TXDATA);
  assign wr_fset   = bus_wr && hit(bus_addr, ADR_FSET);
  assign wr_fclr   = bus_wr && hit(bus_addr, ADR_FCLR);
  assign wr_ien    = bus_wr && hit(bus_addr, ADR_IEN);
  assign wr_route  = bus_wr && hit(bus_addr, ADR_ROUTE);
  assign rd_rx     = bus_rd && hit(bus_addr, ADR_RXDATA);

  logic        sync_q, level_q, tx_en, rx_en;
  logic [31:0] frame_q, clkdiv_q, route_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 1'b0;
      level_q  <= 1'b0;
      frame_q  <= '0;
      clkdiv_q <= '0;
      route_q  <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sync_q  <= bus_wdata[CT_SYNC];
        level_q <= bus_wdata[CT_LEVEL];
      end
      if (wr_frame)  frame_q  <= bus_wdata;
      if (wr_clkdiv) clkdiv_q <= bus_wdata;
      if (wr_route)  route_q  <= bus_wdata & ROUTE_MASK;
      if (wr_cmd) begin
        rx_en <= (rx_en | bus_wdata[CM_RXON]) & ~bus_wdata[CM_RXOFF];
        tx_en <= (tx_en | bus_wdata[CM_TXON]) & ~bus_wdata[CM_TXOFF];
      end
    end
  end

  // transmit side
  logic          tx_push, tx_pop, tx_empty, tx_full;
  logic [CW-1:0] tx_count;

  assign tx_push  = wr_tx && !tx_full;
  assign tx_valid = tx_en && !tx_empty;
  assign tx_pop   = tx_valid && tx_take;

  serctl_fifo #(.W(DW), .DEPTH(DEPTH)) u_txbuf (
    .clk(clk), .rst(rst),
    .push_i(tx_push), .data_i(bus_wdata[DW-1:0]),
    .pop_i(tx_pop), .data_o(tx_word),
    .count_o(tx_count), .empty_o(tx_empty), .full_o(tx_full)
  );

  logic tx_done_now, tx_done_prev, tx_room;

  assign tx_done_now = tx_empty && tx_idle;
  assign tx_room     = level_q ? tx_empty : (tx_count < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) tx_done_prev <= 1'b1;
    else     tx_done_prev <= tx_done_now;
  end

  // receive side
  logic          rx_push, rx_pop, rx_empty, rx_full, rx_lost;
  logic [RW-1:0] rx_head;
  logic [CW-1:0] rx_count;

  assign rx_push = rx_strobe && rx_en && !rx_full;
  assign rx_lost = rx_strobe && rx_en && rx_full;
  assign rx_pop  = rd_rx && !rx_empty;

  serctl_fifo #(.W(RW), .DEPTH(DEPTH)) u_rxbuf (
    .clk(clk), .rst(rst),
    .push_i(rx_push), .data_i({rx_ferr, rx_perr, rx_word}),
    .pop_i(rx_pop), .data_o(rx_head),
    .count_o(rx_count), .empty_o(rx_empty), .full_o(rx_full)
  );

  // interrupt flags
  logic [NFLAG-1:0] fl_set, fl_clr, fl_hw, fl_live, flags, ien;

  always_comb begin
    fl_set  = wr_fset ? bus_wdata[NFLAG-1:0] : '0;
    fl_clr  = wr_fclr ? bus_wdata[NFLAG-1:0] : '0;
    fl_hw   = '0;
    fl_hw[FL_TXDONE] = tx_done_now && !tx_done_prev;
    fl_hw[FL_RXOVF]  = rx_lost;
    fl_live = '0;
    fl_live[FL_TXROOM] = tx_room;
    fl_live[FL_RXAVL]  = !rx_empty;
  end

  serctl_irq #(.NF(NFLAG)) u_irq (
    .clk(clk), .rst(rst),
    .set_i(fl_set), .clr_i(fl_clr), .hw_set_i(fl_hw), .live_i(fl_live),
    .ien_we_i(wr_ien), .ien_d_i(bus_wdata[NFLAG-1:0]),
    .flags_o(flags), .ien_o(ien),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx)
  );

  // registered read path
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (hit(bus_addr, ADR_CTRL)) begin
      rd_next[CT_SYNC]  = sync_q;
      rd_next[CT_LEVEL] = level_q;
    end else if (hit(bus_addr, ADR_FRAME)) begin
      rd_next = frame_q;
    end else if (hit(bus_addr, ADR_STATUS)) begin
      rd_next[ST_TXON]   = tx_en;
      rd_next[ST_TXDONE] = tx_done_now;
      rd_next[ST_TXROOM] = tx_room;
      rd_next[ST_RXAVL]  = !rx_empty;
    end else if (hit(bus_addr, ADR_CLKDIV)) begin
      rd_next = clkdiv_q;
    end else if (hit(bus_addr, ADR_RXDATA)) begin
      if (!rx_empty) begin
        rd_next[DW-1:0] = rx_head[DW-1:0];
        rd_next[RD_PERR] = rx_head[DW];
        rd_next[RD_FERR] = rx_head[DW+1];
      end
    end else if (hit(bus_addr, ADR_FLAGS)) begin
      rd_next[NFLAG-1:0] = flags;
    end else if (hit(bus_addr, ADR_IEN)) begin
      rd_next[NFLAG-1:0] = ien;
    end else if (hit(bus_addr, ADR_ROUTE)) begin
      rd_next = route_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign cfg_sync   = sync_q;
  assign cfg_frame  = frame_q;
  assign cfg_clkdiv = clkdiv_q;
  assign cfg_route  = route_q;
  assign rx_active  = rx_en;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !tx_push) |=> $stable(tx_count)); // R5
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && rx_en && rx_full) |=> flags[FL_RXOVF]); // R10
  AST_RX_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rd_rx) |=> $stable(rx_count)); // R11
endmodule

// File: tb/serctl_regs_tb.sv
module serctl_regs_tb;
  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [DW-1:0] tx_word;
  logic          tx_valid;
  logic          tx_take = 1'b0;
  logic          tx_idle = 1'b1;
  logic [DW-1:0] rx_word = '0;
  logic          rx_perr = 1'b0, rx_ferr = 1'b0, rx_strobe = 1'b0;
  logic          cfg_sync, rx_active, irq_rx, irq_tx;
  logic [31:0]   cfg_frame, cfg_clkdiv, cfg_route;

  always #10 clk = ~clk;

  serctl_regs #(.DW(DW), .DEPTH(2), .AW(8)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_word(tx_word),
    .tx_valid(tx_valid), .tx_take(tx_take), .tx_idle(tx_idle),
    .rx_word(rx_word), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_strobe(rx_strobe),
    .cfg_sync(cfg_sync), .cfg_frame(cfg_frame), .cfg_clkdiv(cfg_clkdiv),
    .cfg_route(cfg_route), .rx_active(rx_active), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  int checks = 0;
  int errors = 0;
  bit eng_ready = 1'b1;
  int busy = 0;
  logic [DW-1:0] txq[$];
  logic [31:0]   rxq[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rcheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bread(a, v);
    check(req, v, exp);
  endtask

  // driver: push a transmit word and record whether it should come out
  task automatic send_tx(input logic [DW-1:0] w, input bit kept);
    if (kept) txq.push_back(w);
    bwrite(8'h34, {{(32-DW){1'b0}}, w});
  endtask

  // driver: deliver a received word and record what a read should return
  task automatic recv(input logic [DW-1:0] w, input bit pe, input bit fe, input bit kept);
    logic [31:0] e;
    e = '0; e[DW-1:0] = w; e[14] = pe; e[15] = fe;
    if (kept) rxq.push_back(e);
    @(negedge clk);
    rx_strobe = 1'b1; rx_word = w; rx_perr = pe; rx_ferr = fe;
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic read_rx(input string req);
    logic [31:0] v, e;
    bread(8'h18, v);
    e = (rxq.size() > 0) ? rxq.pop_front() : 32'h0;
    check(req, v, e);
  endtask

  // monitor: engine model, takes offered words and compares with the queue
  always @(negedge clk) begin
    if (rst) begin
      tx_take = 1'b0; tx_idle = 1'b1; busy = 0;
    end else if (tx_take) begin
      tx_take = 1'b0; busy = 6;
    end else if (tx_valid && eng_ready) begin
      checks++;
      if (txq.size() == 0) begin
        errors++;
        $display("FAIL R4: actual 0x%03h expected no word", tx_word);
      end else begin
        logic [DW-1:0] e;
        e = txq.pop_front();
        if (tx_word !== e) begin
          errors++;
          $display("FAIL R4: actual 0x%03h expected 0x%03h", tx_word, e);
        end
      end
      tx_take = 1'b1; tx_idle = 1'b0;
    end else if (busy > 0) begin
      busy--;
      if (busy == 0) tx_idle = 1'b1;
    end
  end

  bit done = 1'b0;
  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);

    // R1 reset state
    check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    check("R1 irq", {30'b0, irq_tx, irq_rx}, 32'h0);
    rcheck("R1 status", 8'h10, 32'h60);
    rcheck("R1 flags", 8'h40, 32'h2);
    rcheck("R1 ctrl", 8'h00, 32'h0);

    // R2 configuration storage
    bwrite(8'h00, 32'hFFFF_FFFF);
    rcheck("R2 ctrl mask", 8'h00, 32'h1001);
    check("R2 cfg_sync", {31'b0, cfg_sync}, 32'h1);
    bwrite(8'h00, 32'h0);
    bwrite(8'h04, 32'hA5A5_1234);
    rcheck("R2 frame", 8'h04, 32'hA5A5_1234);
    bwrite(8'h14, 32'h0000_1F40);
    rcheck("R2 clkdiv", 8'h14, 32'h0000_1F40);
    bwrite(8'h54, 32'hFFFF_FFFF);
    rcheck("R2 route", 8'h54, 32'h703);
    check("R2 cfg_route", cfg_route, 32'h703);

    // R13 write-only and unmapped addresses
    rcheck("R13 cmd reads 0", 8'h0C, 32'h0);
    rcheck("R13 unmapped", 8'h20, 32'h0);
    rcheck("R13 fset reads 0", 8'h44, 32'h0);

    // R3 command pulses
    bwrite(8'h0C, 32'h4);
    rcheck("R3 tx enable", 8'h10, 32'h62);
    bwrite(8'h0C, 32'hC);
    rcheck("R3 disable wins", 8'h10, 32'h60);
    bwrite(8'h0C, 32'h4);
    bwrite(8'h0C, 32'h8);
    rcheck("R3 tx disable", 8'h10, 32'h60);

    // R5 and R4: disabled transmitter keeps words, full buffer drops the third
    send_tx(9'h055, 1'b1);
    send_tx(9'h1AA, 1'b1);
    send_tx(9'h0FF, 1'b0);
    wait_cyc(10);
    check("R5 no word offered", {31'b0, tx_valid}, 32'h0);
    check("R5 words kept", txq.size(), 32'd2);
    rcheck("R6 full no room", 8'h10, 32'h00);
    rcheck("R7 no done flag", 8'h40, 32'h0);
    bwrite(8'h00, 32'h1000);
    bwrite(8'h0C, 32'h4);
    wait_cyc(30);
    check("R4 all sent", txq.size(), 32'd0);
    rcheck("R6 R7 status empty", 8'h10, 32'h62);
    rcheck("R7 done flag", 8'h40, 32'h3);

    // R6 level select
    bwrite(8'h0C, 32'h8);
    send_tx(9'h101, 1'b1);
    wait_cyc(5);
    rcheck("R6 empty-only level", 8'h10, 32'h00);
    bwrite(8'h00, 32'h0);
    rcheck("R6 one-free level", 8'h10, 32'h40);

    // R8 set and clear
    bwrite(8'h48, 32'h3);
    rcheck("R8 clear keeps live bit", 8'h40, 32'h2);
    bwrite(8'h44, 32'h1);
    rcheck("R8 set done", 8'h40, 32'h3);
    bwrite(8'h48, 32'h1);
    rcheck("R8 clear done", 8'h40, 32'h2);
    bwrite(8'h44, 32'h10);
    rcheck("R8 set overflow", 8'h40, 32'h12);
    bwrite(8'h48, 32'h10);
    rcheck("R8 clear overflow", 8'h40, 32'h2);

    // R12 enables and lines
    bwrite(8'h4C, 32'hFFFF_FFFF);
    rcheck("R12 ien mask", 8'h4C, 32'h17);
    wait_cyc(2);
    check("R12 irq_tx on level", {31'b0, irq_tx}, 32'h1);
    check("R12 irq_rx idle", {31'b0, irq_rx}, 32'h0);
    bwrite(8'h4C, 32'h0);
    wait_cyc(2);
    check("R12 irq_tx masked", {31'b0, irq_tx}, 32'h0);
    bwrite(8'h0C, 32'h4);
    wait_cyc(30);
    check("R5 held word sent", txq.size(), 32'd0);
    rcheck("R7 done again", 8'h40, 32'h3);
    bwrite(8'h48, 32'h1);

    // R9 receive path
    bwrite(8'h0C, 32'h1);
    recv(9'h0A5, 1'b0, 1'b0, 1'b1);
    recv(9'h1C3, 1'b1, 1'b0, 1'b1);
    rcheck("R9 status avail", 8'h10, 32'hE2);
    rcheck("R9 flag avail", 8'h40, 32'h6);
    bwrite(8'h4C, 32'h4);
    wait_cyc(2);
    check("R12 irq_rx on data", {31'b0, irq_rx}, 32'h1);
    read_rx("R9 first word");
    read_rx("R9 parity word");
    rcheck("R9 drained", 8'h10, 32'h62);
    wait_cyc(2);
    check("R12 irq_rx drops", {31'b0, irq_rx}, 32'h0);
    recv(9'h000, 1'b0, 1'b1, 1'b1);
    read_rx("R9 framing word");

    // R10 overflow
    recv(9'h011, 1'b0, 1'b0, 1'b1);
    recv(9'h022, 1'b0, 1'b0, 1'b1);
    recv(9'h033, 1'b0, 1'b0, 1'b0);
    rcheck("R10 overflow flag", 8'h40, 32'h16);
    bwrite(8'h4C, 32'h10);
    wait_cyc(2);
    check("R10 irq_rx overflow", {31'b0, irq_rx}, 32'h1);
    read_rx("R10 kept word 1");
    read_rx("R10 kept word 2");
    read_rx("R9 empty read 0");
    rcheck("R10 sticky", 8'h40, 32'h12);
    bwrite(8'h48, 32'h10);
    wait_cyc(2);
    check("R10 irq_rx cleared", {31'b0, irq_rx}, 32'h0);

    // R11 disabled receiver
    bwrite(8'h0C, 32'h2);
    check("R11 rx_active", {31'b0, rx_active}, 32'h0);
    recv(9'h055, 1'b0, 1'b0, 1'b0);
    rcheck("R11 status", 8'h10, 32'h62);
    read_rx("R11 nothing stored");

    wait_cyc(5);
    check("R4 scoreboard empty", txq.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule